// File: doc/BRIEF.md
# Ethernet Transmit Frame Finisher

This block sits between a transmit buffer reader and the MAC. It receives one outgoing frame at a time as a byte stream with a last-byte marker. The frame already holds the 14-byte header (destination address, source address, type/length) followed by the payload. It forwards every byte to a registered valid/ready byte stream with its own last marker. It can also lengthen the frame in two ways, each chosen per frame by flags from the transmit descriptor.

The first is padding. When it is allowed, a short frame gets zero bytes until 60 bytes have left the block, so the frame reaches 64 bytes once a 4-byte check sequence follows. The second is the CRC-32 frame check sequence. It is appended only when the CRC request and the end-of-packet flag are both set for the segment. It covers header, payload and pad bytes.

A frame whose total length, check sequence included, goes past 1536 bytes is still forwarded whole. A one-beat error flag marks its final byte. Backpressure from the MAC stalls the input without dropping or repeating a byte.

Top module: `eth_tx_finisher`

## Requirements
- R1: After reset, out_valid and out_err are 0. With out_ready high, in_ready is 1.
- R2: With padding and check sequence both off, the output byte sequence equals the input byte sequence. out_last is set only on the final byte.
- R3: With in_pad_en set on the final input byte and fewer than 60 input bytes, zero bytes follow the input until 60 bytes have been emitted. Any check sequence comes after them. A frame of 60 or more bytes gets no padding.
- R4: With in_pad_en clear, a short frame is emitted at its own length with no pad bytes.
- R5: When a check sequence is appended, it is 4 bytes. It is computed as a reflected CRC-32 (reversed polynomial 0xEDB88320, initial value 0xFFFFFFFF) over every emitted frame byte, including pad bytes. The register is inverted and sent least-significant byte first, and out_last sits on its fourth byte.
- R6: A check sequence is appended only when in_crc_en and in_eop are both 1 on the final input byte. Otherwise no check sequence bytes are added.
- R7: in_pad_en, in_crc_en and in_eop are sampled only together with the byte that carries in_last. Their values during earlier bytes have no effect.
- R8: out_err is high for exactly the final byte of a frame whose total emitted length is more than 1536 bytes. It is low on every other beat. A frame of exactly 1536 bytes gets no flag.
- R9: While out_valid is high and out_ready is low, out_data, out_last and out_err hold their values and in_ready is 0. No byte is lost or duplicated.
- R10: While pad or check sequence bytes are still to be generated, in_ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Final byte of the input frame |
| in_pad_en | input | 1 | Pad a short frame (sampled with last byte) |
| in_crc_en | input | 1 | Request check sequence (sampled with last byte) |
| in_eop | input | 1 | Segment ends the packet (sampled with last byte) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | MAC accepts an output byte |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Final byte of the output frame |
| out_err | output | 1 | Oversize flag on the final byte |

## Verification
The oversize decision and the end of the check sequence land on the same output beat. The length judgement has to include the four check sequence bytes that do not exist until after the last input byte. Frames of 1532 and 1533 input bytes with the check sequence on provoke this, because they put the total at exactly 1536 and 1537. MAC stalls held across that final beat test it further. The bench judges that the flag appears only on the beat carrying out_last and only for the longer frame, and that it stays steady while stalled. Short frames that need both padding and a check sequence put the switch from padding to check sequence in the same stall pattern.

// File: rtl/ethf_pkg.sv
package ethf_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    ST_BODY = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } ethf_state_e;
endpackage

// File: rtl/ethf_crc8.sv
module ethf_crc8 import ethf_pkg::*; (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [0:BYTE_W];

  assign stage[0] = crc_i;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
    assign stage[g+1] = (stage[g] >> 1) ^
                        ((stage[g][0] ^ byte_i[g]) ? CRC_POLY_REFL : '0);
  end

  assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/ethf_sat_ctr.sv
module ethf_sat_ctr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_inc
);
  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en)    cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/ethf_out_stage.sv
module ethf_out_stage import ethf_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_data,
  input  logic              ld_last,
  input  logic              ld_err,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              out_err,
  output logic              load_ok
);
  assign load_ok = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_err   <= 1'b0;
    end else if (ld) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_last  <= ld_last;
      out_err   <= ld_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_err   <= 1'b0;
    end
  end
endmodule

// File: rtl/eth_tx_finisher.sv
module eth_tx_finisher import ethf_pkg::*; #(
  parameter int MIN_BODY  = 60,
  parameter int MAX_FRAME = 1536,
  parameter int FCS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_pad_en,
  input  logic              in_crc_en,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              out_err
);
  localparam int CNT_W = $clog2(MAX_FRAME + FCS_BYTES + 2);
  localparam int IDX_W = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
  localparam logic [CNT_W-1:0] MIN_C      = CNT_W'(MIN_BODY);
  localparam logic [CNT_W-1:0] MAX_C      = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W:0]   MAX_WIDE   = (CNT_W+1)'(MAX_FRAME);
  localparam logic [CNT_W:0]   FCS_WIDE   = (CNT_W+1)'(FCS_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(FCS_BYTES - 1);

  ethf_state_e       st_q, st_d;
  logic [CRC_W-1:0]  crc_q, crc_next;
  logic [BYTE_W-1:0] crc_byte;
  logic              fcs_pend_q, fcs_pend_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_inc;
  logic [CNT_W:0]    fcs_total;
  logic              load_ok, take;
  logic              ld, ld_last, ld_err;
  logic [BYTE_W-1:0] ld_data;
  logic              cnt_en, cnt_clr, crc_upd, crc_rst, crc_shift;
  logic              want_fcs;

  assign in_ready  = (st_q == ST_BODY) && load_ok;
  assign take      = in_valid && in_ready;
  assign crc_byte  = (st_q == ST_PAD) ? '0 : in_data;
  assign fcs_total = {1'b0, cnt_q} + FCS_WIDE;
  assign want_fcs  = in_crc_en && in_eop;

  ethf_crc8 u_crc (
    .crc_i  (crc_q),
    .byte_i (crc_byte),
    .crc_o  (crc_next)
  );

  ethf_sat_ctr #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .en      (cnt_en),
    .cnt_q   (cnt_q),
    .cnt_inc (cnt_inc)
  );

  ethf_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .ld        (ld),
    .ld_data   (ld_data),
    .ld_last   (ld_last),
    .ld_err    (ld_err),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_err   (out_err),
    .load_ok   (load_ok)
  );

  always_comb begin
    st_d       = st_q;
    fcs_pend_d = fcs_pend_q;
    idx_d      = idx_q;
    ld         = 1'b0;
    ld_data    = in_data;
    ld_last    = 1'b0;
    ld_err     = 1'b0;
    cnt_en     = 1'b0;
    cnt_clr    = 1'b0;
    crc_upd    = 1'b0;
    crc_rst    = 1'b0;
    crc_shift  = 1'b0;
    case (st_q)
      ST_BODY: begin
        if (take) begin
          ld      = 1'b1;
          cnt_en  = 1'b1;
          crc_upd = 1'b1;
          if (in_last) begin
            fcs_pend_d = want_fcs;
            idx_d      = '0;
            if (in_pad_en && (cnt_inc < MIN_C)) begin
              st_d = ST_PAD;
            end else if (want_fcs) begin
              st_d = ST_FCS;
            end else begin
              ld_last = 1'b1;
              ld_err  = cnt_inc > MAX_C;
              cnt_clr = 1'b1;
              crc_rst = 1'b1;
            end
          end
        end
      end
      ST_PAD: begin
        if (load_ok) begin
          ld      = 1'b1;
          ld_data = '0;
          cnt_en  = 1'b1;
          crc_upd = 1'b1;
          if (cnt_inc >= MIN_C) begin
            if (fcs_pend_q) begin
              st_d = ST_FCS;
            end else begin
              st_d    = ST_BODY;
              ld_last = 1'b1;
              ld_err  = cnt_inc > MAX_C;
              cnt_clr = 1'b1;
              crc_rst = 1'b1;
            end
          end
        end
      end
      ST_FCS: begin
        if (load_ok) begin
          ld        = 1'b1;
          ld_data   = ~crc_q[BYTE_W-1:0];
          crc_shift = 1'b1;
          idx_d     = idx_q + IDX_W'(1);
          if (idx_q == LAST_IDX) begin
            st_d    = ST_BODY;
            ld_last = 1'b1;
            ld_err  = fcs_total > MAX_WIDE;
            cnt_clr = 1'b1;
            crc_rst = 1'b1;
          end
        end
      end
      default: st_d = ST_BODY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_BODY;
      fcs_pend_q <= 1'b0;
      idx_q      <= '0;
      crc_q      <= CRC_SEED;
    end else begin
      st_q       <= st_d;
      fcs_pend_q <= fcs_pend_d;
      idx_q      <= idx_d;
      if (crc_rst)        crc_q <= CRC_SEED;
      else if (crc_upd)   crc_q <= crc_next;
      else if (crc_shift) crc_q <= crc_q >> BYTE_W;
    end
  end
endmodule

// File: rtl/ethf_checker.sv
module ethf_checker #(
  parameter int MAX_FRAME = 1536
) (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_err
);
  localparam int CW = $clog2(MAX_FRAME + 8);
  localparam logic [CW:0] MAX_W = (CW+1)'(MAX_FRAME);

  logic [CW-1:0] ocnt;

  always_ff @(posedge clk) begin
    if (rst) ocnt <= '0;
    else if (out_valid && out_ready) begin
      if (out_last)    ocnt <= '0;
      else if (~&ocnt) ocnt <= ocnt + CW'(1);
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_err)); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_last) && $stable(out_err))); // R9

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_ERR_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> out_last); // R8

  AST_ERR_MATCHES_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (out_err == (({1'b0, ocnt} + (CW+1)'(1)) > MAX_W))); // R8
endmodule

bind eth_tx_finisher ethf_checker #(.MAX_FRAME(MAX_FRAME)) u_ethf_checker (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_err   (out_err)
);

// File: tb/test_eth_tx_finisher.sv
`timescale 1ns/1ps
module test_eth_tx_finisher;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_pad_en = 1'b0;
  logic       in_crc_en = 1'b0;
  logic       in_eop = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;
  logic       out_err;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  logic [7:0] exp_mem [0:2047];

  always #10 clk = ~clk;

  eth_tx_finisher i_eth_tx_finisher (
    .clk, .rst, .in_valid, .in_ready, .in_data, .in_last,
    .in_pad_en, .in_crc_en, .in_eop, .out_valid, .out_ready,
    .out_data, .out_last, .out_err
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit rnd(input int pct);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return (lfsr % 100) < pct;
  endfunction

  task automatic run_frame(input int len, input bit pad, input bit crc,
                           input bit eop, input int ready_pct, input bit flip,
                           input int fid);
    int body, exp_len, in_idx, got, mism, first_bad, last_pos;
    bit crc_on, padded, exp_err, fin, err_seen, err_off_last;
    bit prev_stall, stall_bad, rdy_bad;
    logic [7:0] pd;
    logic pl, pe;
    logic [31:0] c;
    string tag_len, tag_dat;
    crc_on  = crc && eop;
    body    = (pad && len < 60) ? 60 : len;
    padded  = body > len;
    exp_len = body + (crc_on ? 4 : 0);
    exp_err = exp_len > 1536;
    for (int i = 0; i < body; i++)
      exp_mem[i] = (i < len) ? 8'((i * 7 + fid * 13 + 1) & 255) : 8'h00;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < body; i++) begin
      c = c ^ {24'h0, exp_mem[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    if (crc_on)
      for (int k = 0; k < 4; k++) exp_mem[body + k] = c[8*k +: 8];

    in_idx = 0; got = 0; mism = 0; first_bad = -1; last_pos = -1;
    fin = 0; err_seen = 0; err_off_last = 0;
    prev_stall = 0; stall_bad = 0; rdy_bad = 0;
    pd = '0; pl = 0; pe = 0;
    while (!fin && !finished) begin
      @(negedge clk);
      if (in_idx < len) begin
        in_valid = rnd(80);
        in_data  = exp_mem[in_idx];
        in_last  = (in_idx == len - 1);
        if (flip && in_idx != len - 1) begin
          in_pad_en = !pad; in_crc_en = !crc; in_eop = !eop;
        end else begin
          in_pad_en = pad; in_crc_en = crc; in_eop = eop;
        end
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      out_ready = rnd(ready_pct);
      #1;
      if (prev_stall && !(out_valid && out_data == pd && out_last == pl && out_err == pe))
        stall_bad = 1;
      if (in_idx >= len && (got + int'(out_valid)) < exp_len && in_ready)
        rdy_bad = 1;
      if (out_valid && out_ready) begin
        if (got < 2048) begin
          if (got >= exp_len || out_data != exp_mem[got]) begin
            mism++;
            if (first_bad < 0) first_bad = got;
          end
        end
        if (out_err) begin
          err_seen = 1;
          if (!out_last) err_off_last = 1;
        end
        if (out_last) begin
          fin = 1;
          last_pos = got;
        end
        got++;
      end
      prev_stall = out_valid && !out_ready;
      pd = out_data; pl = out_last; pe = out_err;
      if (in_valid && in_ready) in_idx++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;

    if (flip)                     tag_len = "R7";
    else if (crc != eop)          tag_len = "R6";
    else if (!pad && len < 60)    tag_len = "R4";
    else if (padded)              tag_len = "R3";
    else                          tag_len = "R2";
    tag_dat = crc_on ? "R5" : (flip ? "R7" : (padded ? "R3" : "R2"));

    chk(got == exp_len && last_pos == exp_len - 1, tag_len, "frame length", got, exp_len);
    chk(mism == 0, tag_dat, "byte mismatches (first bad index in actual)", first_bad, -1);
    chk(err_seen == exp_err && !err_off_last, "R8", "oversize flag", int'(err_seen), int'(exp_err));
    if (ready_pct < 100)
      chk(!stall_bad, "R9", "output held during stall", int'(stall_bad), 0);
    if (exp_len > len)
      chk(!rdy_bad, "R10", "in_ready low while generating", int'(rdy_bad), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired before end of run");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    out_ready = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(out_err == 1'b0, "R1", "out_err after reset", int'(out_err), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // Sweep of short lengths over every flag combination, mixed backpressure
    for (int len = 1; len <= 64; len++)
      for (int f = 0; f < 8; f++)
        run_frame(len, f[0], f[1], f[2], ((len + f) % 3 == 0) ? 100 :
                  (((len + f) % 3 == 1) ? 50 : 75), 1'b0, len * 8 + f);

    // R7: flags differ on non-final bytes
    run_frame(10, 1'b1, 1'b1, 1'b1, 60, 1'b1, 900);
    run_frame(10, 1'b0, 1'b0, 1'b0, 60, 1'b1, 901);
    run_frame(70, 1'b0, 1'b1, 1'b1, 100, 1'b1, 902);

    // R8 boundaries around the maximum, with and without check sequence
    run_frame(1532, 1'b1, 1'b1, 1'b1, 100, 1'b0, 910);
    run_frame(1533, 1'b1, 1'b1, 1'b1, 50,  1'b0, 911);
    run_frame(1536, 1'b0, 1'b0, 1'b0, 100, 1'b0, 912);
    run_frame(1537, 1'b0, 1'b0, 1'b0, 70,  1'b0, 913);
    run_frame(1533, 1'b0, 1'b1, 1'b0, 100, 1'b0, 914);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule